// File: doc/BRIEF.md
# Debug Mode Entry and Return Controller

This block keeps a processor's status word and steers its program counter into and out of a debug mode. When a debug request is accepted, the program counter of the interrupted instruction and the current status word are copied into two dedicated return registers. Nothing is written to the stack. In the same step the status word gains its debug flag, its mode field is set to the exception context, and a one-cycle redirect sends fetch to a fixed handler address.

A return strobe issued while in debug reloads the saved status word, which also clears the debug flag, and redirects fetch back to the saved program counter. While in debug, software may rewrite the mode field to look at other contexts, and the privilege output stays asserted whatever that field holds. Outside debug, the status word is an ordinary register that software writes as a whole, except that it can never set the debug flag. Instruction decode, pipeline flushing and memory are handled elsewhere.

Top module: `dbgmode_ctl`

## Requirements
- R1: After reset the status word equals the reset value `RST_SR` with the debug flag (bit `DBG_POS`, default 7) clear, the redirect output is low and privilege is low for the default reset value.
- R2: A debug request seen while the debug flag is clear produces, on the next cycle, a one-cycle redirect to `HANDLER_PC`, and a status word with the debug flag set, the mode field (bits `MODE_LSB` upward, `MODE_W` wide, default bits 2:0) equal to `EXC_MODE` (default 5), and every other bit unchanged.
- R3: Debug entry captures the current program counter and the status word into dedicated return registers, and these are the values later used by the return.
- R4: A return strobe seen while the debug flag is set restores, on the next cycle, the exact status word saved at entry, with the debug flag clear, and pulses the redirect with the saved program counter.
- R5: The redirect valid output is high for exactly one cycle per accepted entry or return.
- R6: A debug request while the debug flag is already set is ignored: no redirect, the status word is unchanged, and the saved return values are kept.
- R7: A return strobe while the debug flag is clear is ignored: no redirect and the status word is unchanged.
- R8: A status write while in debug changes only the mode field. The debug flag and all other bits are kept.
- R9: A status write outside debug loads the whole word, except that the debug flag stays clear.
- R10: Privilege is high whenever the debug flag is set, for any mode value. Outside debug it is high exactly when the mode field differs from `USER_MODE` (default 0).
- R11: A status write in the same cycle as an accepted entry or return is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| dbg_req_i | input | 1 | Debug entry request |
| dbg_ret_i | input | 1 | Return-from-debug strobe |
| cur_pc_i | input | PC_W | Program counter of the interrupted instruction |
| sr_wr_i | input | 1 | Status word write enable |
| sr_wdata_i | input | SR_W | Status word write data |
| redir_vld_o | output | 1 | One-cycle fetch redirect pulse |
| redir_pc_o | output | PC_W | Redirect target address |
| sr_o | output | SR_W | Live status word |
| priv_o | output | 1 | Full privilege indication |

## Verification
A wrong saved program counter or status word stays hidden until the return. It then shows on the cycle after the strobe as a wrong redirect target or a wrong restored status word, so every entry is paired with a return. A debug flag held in the wrong state shows one cycle after the event on `sr_o` and `priv_o`, and also as a missing or extra redirect pulse. The sweep covers all 256 status values, so a masking error on the debug flag or the mode field shows within the first iterations that touch the affected bit.

// File: rtl/dbgmode_pkg.sv
package dbgmode_pkg;
    typedef enum logic [1:0] {
        DEV_NONE   = 2'd0,
        DEV_ENTER  = 2'd1,
        DEV_RETURN = 2'd2
    } dbg_ev_e;
endpackage

// File: rtl/dbgmode_ctx.sv
module dbgmode_ctx
    import dbgmode_pkg::*;
#(
    parameter int PC_W = 16,
    parameter int SR_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  dbg_ev_e         ev_i,
    input  logic [PC_W-1:0] cur_pc_i,
    input  logic [SR_W-1:0] cur_sr_i,
    output logic [PC_W-1:0] ret_pc_o,
    output logic [SR_W-1:0] ret_sr_o
);
    typedef struct packed {
        logic [PC_W-1:0] pc;
        logic [SR_W-1:0] sr;
    } ctx_t;

    ctx_t ctx_d, ctx_q;

    always_comb begin
        ctx_d = ctx_q;
        if (ev_i == DEV_ENTER) begin
            ctx_d.pc = cur_pc_i;
            ctx_d.sr = cur_sr_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctx_q <= '0;
        else        ctx_q <= ctx_d;
    end

    assign ret_pc_o = ctx_q.pc;
    assign ret_sr_o = ctx_q.sr;

    // R6: saved context only moves on an accepted entry
    assert_ctx_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_i != DEV_ENTER) |=> ($stable(ret_pc_o) && $stable(ret_sr_o)));
endmodule

// File: rtl/dbgmode_sr.sv
module dbgmode_sr
    import dbgmode_pkg::*;
#(
    parameter int              SR_W     = 8,
    parameter int              DBG_POS  = 7,
    parameter int              MODE_LSB = 0,
    parameter int              MODE_W   = 3,
    parameter int              EXC_MODE = 5,
    parameter logic [SR_W-1:0] RST_SR   = '0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  dbg_ev_e         ev_i,
    input  logic            wr_i,
    input  logic [SR_W-1:0] wdata_i,
    input  logic [SR_W-1:0] ret_sr_i,
    output logic [SR_W-1:0] sr_o
);
    localparam logic [SR_W-1:0] D_MASK    = SR_W'(1) << DBG_POS;
    localparam logic [SR_W-1:0] MODE_MASK = SR_W'(((1 << MODE_W) - 1) << MODE_LSB);
    localparam logic [SR_W-1:0] EXC_BITS  = SR_W'(EXC_MODE << MODE_LSB) & MODE_MASK;

    typedef struct packed {
        logic [SR_W-1:0] sr;
    } sr_state_t;

    sr_state_t st_d, st_q;
    logic      in_dbg;

    assign in_dbg = st_q.sr[DBG_POS];

    always_comb begin
        st_d = st_q;
        unique case (ev_i)
            DEV_ENTER:  st_d.sr = (st_q.sr & ~MODE_MASK) | D_MASK | EXC_BITS;
            DEV_RETURN: st_d.sr = ret_sr_i & ~D_MASK;
            default: begin
                if (wr_i) begin
                    if (in_dbg) st_d.sr = (st_q.sr & ~MODE_MASK) | (wdata_i & MODE_MASK);
                    else        st_d.sr = wdata_i & ~D_MASK;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q.sr <= RST_SR & ~D_MASK;
        else        st_q    <= st_d;
    end

    assign sr_o = st_q.sr;

    assert_entry_sets_d_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_i == DEV_ENTER) |=> (sr_o[DBG_POS] && ((sr_o & MODE_MASK) == EXC_BITS)));

    assert_return_clears_d_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_i == DEV_RETURN) |=> !sr_o[DBG_POS]);

    assert_dbg_write_mode_only_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_dbg && ev_i == DEV_NONE) |=> (sr_o[DBG_POS] &&
            ((sr_o & ~MODE_MASK) == ($past(sr_o) & ~MODE_MASK))));

    assert_no_d_outside_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_dbg && ev_i != DEV_ENTER) |=> !sr_o[DBG_POS]);
endmodule

// File: rtl/dbgmode_redir.sv
module dbgmode_redir
    import dbgmode_pkg::*;
#(
    parameter int              PC_W       = 16,
    parameter logic [PC_W-1:0] HANDLER_PC = '0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  dbg_ev_e         ev_i,
    input  logic [PC_W-1:0] ret_pc_i,
    output logic            vld_o,
    output logic [PC_W-1:0] pc_o
);
    typedef struct packed {
        logic            vld;
        logic [PC_W-1:0] pc;
    } rd_t;

    rd_t rd_d, rd_q;

    always_comb begin
        rd_d     = rd_q;
        rd_d.vld = 1'b0;
        unique case (ev_i)
            DEV_ENTER:  begin rd_d.vld = 1'b1; rd_d.pc = HANDLER_PC; end
            DEV_RETURN: begin rd_d.vld = 1'b1; rd_d.pc = ret_pc_i;   end
            default:    ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rd_q <= '0;
        else        rd_q <= rd_d;
    end

    assign vld_o = rd_q.vld;
    assign pc_o  = rd_q.pc;

    assert_pulse_one_cycle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (vld_o && ev_i == DEV_NONE) |=> !vld_o);

    assert_entry_target_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_i == DEV_ENTER) |=> (vld_o && pc_o == HANDLER_PC));
endmodule

// File: rtl/dbgmode_ctl.sv
module dbgmode_ctl
    import dbgmode_pkg::*;
#(
    parameter int              PC_W       = 16,
    parameter int              SR_W       = 8,
    parameter int              DBG_POS    = 7,
    parameter int              MODE_LSB   = 0,
    parameter int              MODE_W     = 3,
    parameter int              EXC_MODE   = 5,
    parameter int              USER_MODE  = 0,
    parameter logic [PC_W-1:0] HANDLER_PC = 16'hA000,
    parameter logic [SR_W-1:0] RST_SR     = 8'h00
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            dbg_req_i,
    input  logic            dbg_ret_i,
    input  logic [PC_W-1:0] cur_pc_i,
    input  logic            sr_wr_i,
    input  logic [SR_W-1:0] sr_wdata_i,
    output logic            redir_vld_o,
    output logic [PC_W-1:0] redir_pc_o,
    output logic [SR_W-1:0] sr_o,
    output logic            priv_o
);
    localparam logic [MODE_W-1:0] USER_VAL = MODE_W'(USER_MODE);

    dbg_ev_e         ev;
    logic            in_dbg;
    logic [PC_W-1:0] ret_pc;
    logic [SR_W-1:0] ret_sr;
    logic [SR_W-1:0] sr_q;

    assign in_dbg = sr_q[DBG_POS];

    always_comb begin
        ev = DEV_NONE;
        if (in_dbg) begin
            if (dbg_ret_i) ev = DEV_RETURN;
        end else begin
            if (dbg_req_i) ev = DEV_ENTER;
        end
    end

    dbgmode_ctx #(.PC_W(PC_W), .SR_W(SR_W)) u_ctx (
        .clk      (clk),
        .rst_n    (rst_n),
        .ev_i     (ev),
        .cur_pc_i (cur_pc_i),
        .cur_sr_i (sr_q),
        .ret_pc_o (ret_pc),
        .ret_sr_o (ret_sr)
    );

    dbgmode_sr #(
        .SR_W(SR_W), .DBG_POS(DBG_POS), .MODE_LSB(MODE_LSB),
        .MODE_W(MODE_W), .EXC_MODE(EXC_MODE), .RST_SR(RST_SR)
    ) u_sr (
        .clk      (clk),
        .rst_n    (rst_n),
        .ev_i     (ev),
        .wr_i     (sr_wr_i),
        .wdata_i  (sr_wdata_i),
        .ret_sr_i (ret_sr),
        .sr_o     (sr_q)
    );

    dbgmode_redir #(.PC_W(PC_W), .HANDLER_PC(HANDLER_PC)) u_redir (
        .clk      (clk),
        .rst_n    (rst_n),
        .ev_i     (ev),
        .ret_pc_i (ret_pc),
        .vld_o    (redir_vld_o),
        .pc_o     (redir_pc_o)
    );

    assign sr_o   = sr_q;
    assign priv_o = in_dbg || (sr_q[MODE_LSB +: MODE_W] != USER_VAL);

    assert_req_ignored_in_dbg_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_dbg && dbg_req_i && !dbg_ret_i) |=> (!redir_vld_o && sr_o[DBG_POS]));

    assert_ret_ignored_outside_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_dbg && dbg_ret_i && !dbg_req_i && !sr_wr_i) |=> (!redir_vld_o && $stable(sr_o)));

    assert_priv_in_dbg_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (in_dbg && !dbg_ret_i) |=> priv_o);

    assert_return_target_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_dbg && dbg_ret_i) |=> (redir_vld_o && redir_pc_o == $past(ret_pc)));
endmodule

// File: tb/dbgmode_ctl_tb.sv
module dbgmode_ctl_tb;
    localparam int          PC_W    = 16;
    localparam int          SR_W    = 8;
    localparam logic [15:0] HANDLER = 16'hA000;
    localparam logic [7:0]  DBIT    = 8'h80;
    localparam logic [7:0]  MMASK   = 8'h07;
    localparam logic [7:0]  EXC     = 8'h05;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            dbg_req_i = 1'b0;
    logic            dbg_ret_i = 1'b0;
    logic [PC_W-1:0] cur_pc_i = '0;
    logic            sr_wr_i = 1'b0;
    logic [SR_W-1:0] sr_wdata_i = '0;
    logic            redir_vld_o;
    logic [PC_W-1:0] redir_pc_o;
    logic [SR_W-1:0] sr_o;
    logic            priv_o;

    int total = 0;
    int bad   = 0;

    always #10 clk = ~clk;

    dbgmode_ctl u_dut (
        .clk(clk), .rst_n(rst_n), .dbg_req_i(dbg_req_i), .dbg_ret_i(dbg_ret_i),
        .cur_pc_i(cur_pc_i), .sr_wr_i(sr_wr_i), .sr_wdata_i(sr_wdata_i),
        .redir_vld_o(redir_vld_o), .redir_pc_o(redir_pc_o), .sr_o(sr_o), .priv_o(priv_o)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle_inputs();
        dbg_req_i = 1'b0; dbg_ret_i = 1'b0; sr_wr_i = 1'b0;
    endtask

    initial begin
        #(200000 * 20);
        total++; bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        step();
        chk("R1 sr", 32'(sr_o), 32'h0);
        chk("R1 vld", 32'(redir_vld_o), 32'h0);
        chk("R1 priv", 32'(priv_o), 32'h0);

        for (int v = 0; v < 256; v++) begin
            logic [7:0]  vv;
            logic [7:0]  base;
            logic [7:0]  ent;
            logic [7:0]  m;
            logic [15:0] pc;
            vv   = 8'(v);
            base = vv & ~DBIT;
            ent  = (base & ~MMASK) | DBIT | EXC;
            m    = (vv ^ 8'h03) & MMASK;
            pc   = {vv ^ 8'h5A, ~vv};

            // outside-debug write of the whole word
            sr_wr_i = 1'b1; sr_wdata_i = vv;
            step(); idle_inputs();
            chk("R9 write", 32'(sr_o), 32'(base));
            chk("R10 priv outside", 32'(priv_o), 32'((base & MMASK) != 0));
            chk("R5 no pulse", 32'(redir_vld_o), 32'h0);

            // return strobe while not in debug
            dbg_ret_i = 1'b1;
            step(); idle_inputs();
            chk("R7 sr", 32'(sr_o), 32'(base));
            chk("R7 vld", 32'(redir_vld_o), 32'h0);

            // entry with a concurrent write that must be discarded
            dbg_req_i = 1'b1; cur_pc_i = pc; sr_wr_i = 1'b1; sr_wdata_i = ~vv;
            step(); idle_inputs();
            chk("R2 vld", 32'(redir_vld_o), 32'h1);
            chk("R2 pc", 32'(redir_pc_o), 32'(HANDLER));
            chk("R2 R11 sr", 32'(sr_o), 32'(ent));
            chk("R10 priv entry", 32'(priv_o), 32'h1);

            step();
            chk("R5 pulse end", 32'(redir_vld_o), 32'h0);

            // repeated request in debug, plus a mode write that also tries to clear D
            dbg_req_i = 1'b1; cur_pc_i = ~pc; sr_wr_i = 1'b1;
            sr_wdata_i = (~vv & ~DBIT & ~MMASK) | m;
            step(); idle_inputs();
            chk("R6 vld", 32'(redir_vld_o), 32'h0);
            chk("R8 sr", 32'(sr_o), 32'((ent & ~MMASK) | m));
            chk("R10 priv any mode", 32'(priv_o), 32'h1);

            // return with a concurrent write that must be discarded
            dbg_ret_i = 1'b1; sr_wr_i = 1'b1; sr_wdata_i = 8'h7F;
            step(); idle_inputs();
            chk("R3 R6 pc", 32'(redir_pc_o), 32'(pc));
            chk("R4 vld", 32'(redir_vld_o), 32'h1);
            chk("R4 R11 sr", 32'(sr_o), 32'(base));
            chk("R10 priv after return", 32'(priv_o), 32'((base & MMASK) != 0));

            step();
            chk("R5 return pulse end", 32'(redir_vld_o), 32'h0);
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule